// File: doc/BRIEF.md
# Return Address Stack Predictor

This unit predicts where a subroutine return will jump for an in-order fetch front end whose stages are PC, F1, F2, D1, D2, RN, RF and EX. When the decode stage D2 sees a call, the unit stores the link address that decode supplies on a small circular stack. When D2 sees a return, the unit pops the top entry and gives fetch a redirect in that same cycle. The alternative is to wait until the return has read its link register in RF, so the prediction removes two bubbles.

The popped address travels in a two-stage prediction pipeline alongside the return. When the return reaches RF, the real link-register value is compared with it. If they agree, nothing happens. If they disagree, or if the prediction came from an empty stack, the unit drives a corrected PC and kill strobes for the younger fetch stages. A build-time option also kills D1, for a slow compare. A flush from an older instruction drops the D2 instruction and every prediction still in flight.

The stack tracks its occupancy with a three-state machine:
- OCC_EMPTY moves to OCC_PARTIAL on a push, or to OCC_FULL when the depth is one.
- OCC_PARTIAL moves to OCC_FULL on a push that fills the last slot, and to OCC_EMPTY on a pop of the last entry.
- OCC_FULL stays in OCC_FULL on a push, which overwrites the oldest entry. It moves to OCC_PARTIAL on a pop.
- A pop in OCC_EMPTY stays in OCC_EMPTY.

Top module: `ras_predictor`

## Requirements
- R1: A call decoded in D2 (d2_valid=1, d2_is_call=1, d2_is_ret=0) pushes d2_link_addr. Later returns pop entries in last-in, first-out order.
- R2: redir_valid is high only in the cycle a return is decoded in D2, and only with stack prediction enabled. In that cycle redir_pc is the top-of-stack entry and redir_hit=1 when the stack held an entry.
- R3: The check of a return happens in the cycle two clocks after its D2 cycle, when rf_link_val carries the real link value. On a mismatch, fix_valid=1 and fix_pc=rf_link_val.
- R4: When the carried prediction was a real entry and equals rf_link_val, fix_valid, kill_f1, kill_f2 and kill_d1 all stay low.
- R5: On a mismatch, kill_f1=kill_f2=1. kill_d1 is also 1 only when SLOW_CMP=1, which makes the penalty 3 cycles instead of 2.
- R6: With DEPTH=8, a push onto a full stack overwrites the oldest entry. After 9 pushes, the next 8 pops return pushes 9 down to 2 with redir_hit=1, and a 9th pop gives redir_hit=0.
- R7: A pop on an empty stack still asserts redir_valid, with redir_hit=0 and redir_pc taken from the current pointer slot (0 after reset). At the check it counts as a mismatch even if rf_link_val equals redir_pc.
- R8: While older_flush=1, the D2 instruction has no effect: no push, no pop, no redirect. Every return then in RN or RF, or entering RN, produces no fix in that cycle or any later cycle.
- R9: An instruction that is both call and return predicts the current top and then replaces the top with d2_link_addr, leaving the depth unchanged.
- R10: With USE_STACK=0, redir_valid never rises and every return is corrected at RF. Counting from the return's PC cycle, this gives 6 bubbles against 4 with the stack.
- R11: After reset the stack is empty, its storage is zero, and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d2_valid | input | 1 | D2 holds a valid instruction |
| d2_is_call | input | 1 | D2 instruction is a call-type jump |
| d2_is_ret | input | 1 | D2 instruction is a return |
| d2_link_addr | input | AW | Link address to push, computed by decode |
| rf_link_val | input | AW | Link register value read in RF |
| older_flush | input | 1 | Flush caused by an older instruction |
| redir_valid | output | 1 | Early fetch redirect from D2 |
| redir_pc | output | AW | Predicted return address |
| redir_hit | output | 1 | Prediction came from a real stack entry |
| fix_valid | output | 1 | Mispredict correction from RF |
| fix_pc | output | AW | Corrected PC |
| kill_f1 | output | 1 | Kill the F1 instruction |
| kill_f2 | output | 1 | Kill the F2 instruction |
| kill_d1 | output | 1 | Kill the D1 instruction (slow-compare build) |

## Verification
The assertions check several properties on every cycle:
- the occupancy state agrees with the entry count;
- a push below full grows the count;
- redirects appear only with a decoded return;
- a correction is always preceded, two cycles earlier, by a return;
- nothing is corrected in the cycle after a flush;
- D1 is never killed without F1 and F2;
- a matching real prediction stays quiet.

Only the bench scenarios can show the data behaviour: last-in, first-out ordering, overwrite of the oldest entry, the value and flag of an empty-stack pop, the call-plus-return replacement, and the 4-versus-6 bubble count of the two build modes.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

endpackage

// File: rtl/ras_stack.sv
module ras_stack
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] link_in,
    output logic [AW-1:0] top_addr,
    output logic          top_hit
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

    logic [AW-1:0] slot_q [DEPTH];
    logic [PW-1:0] tos_q, tos_up, tos_dn;
    logic [CW-1:0] cnt_q, cnt_nxt;
    occ_e          state_q, state_nxt;

    logic push_only, pop_only, swap;

    assign push_only = push & ~pop;
    assign pop_only  = pop & ~push;
    assign swap      = push & pop;
    assign tos_up    = (tos_q == LAST_SLOT) ? '0 : tos_q + 1'b1;
    assign tos_dn    = (tos_q == '0) ? LAST_SLOT : tos_q - 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    // next state and count
    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push) begin
                    cnt_nxt   = CW'(1);
                    state_nxt = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
                end
            end
            OCC_PARTIAL: begin
                if (push_only) begin
                    cnt_nxt = cnt_q + 1'b1;
                    if (cnt_q == FULL_CNT - 1'b1) state_nxt = OCC_FULL;
                end else if (pop_only) begin
                    cnt_nxt = cnt_q - 1'b1;
                    if (cnt_q == CW'(1)) state_nxt = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                if (pop_only) begin
                    cnt_nxt   = cnt_q - 1'b1;
                    state_nxt = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
                end
            end
            default: begin
                state_nxt = OCC_EMPTY;
                cnt_nxt   = '0;
            end
        endcase
    end

    // storage and pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tos_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (push_only) begin
            tos_q         <= tos_up;
            slot_q[tos_up] <= link_in;
        end else if (swap) begin
            slot_q[tos_q] <= link_in;
        end else if (pop_only && state_q != OCC_EMPTY) begin
            tos_q <= tos_dn;
        end
    end

    // outputs
    always_comb begin
        top_addr = slot_q[tos_q];
        unique case (state_q)
            OCC_EMPTY:   top_hit = 1'b0;
            OCC_PARTIAL: top_hit = 1'b1;
            OCC_FULL:    top_hit = 1'b1;
            default:     top_hit = 1'b0;
        endcase
    end

    AST_OCC_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == OCC_EMPTY) == (cnt_q == '0)) &&
        ((state_q == OCC_FULL) == (cnt_q == FULL_CNT))); // R6

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_only && state_q != OCC_FULL) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1

endmodule

// File: rtl/ras_pipe.sv
module ras_pipe #(
    parameter int STAGES = 2,
    parameter int AW     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          in_vld,
    input  logic          in_hit,
    input  logic [AW-1:0] in_addr,
    output logic          out_vld,
    output logic          out_hit,
    output logic [AW-1:0] out_addr
);

    logic          vld_q  [STAGES];
    logic          hit_q  [STAGES];
    logic [AW-1:0] addr_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic          src_vld, src_hit;
        logic [AW-1:0] src_addr;
        if (s == 0) begin : g_head
            assign src_vld  = in_vld;
            assign src_hit  = in_hit;
            assign src_addr = in_addr;
        end else begin : g_body
            assign src_vld  = vld_q[s-1];
            assign src_hit  = hit_q[s-1];
            assign src_addr = addr_q[s-1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s]  <= 1'b0;
                hit_q[s]  <= 1'b0;
                addr_q[s] <= '0;
            end else begin
                vld_q[s]  <= src_vld & ~flush;
                hit_q[s]  <= src_hit;
                addr_q[s] <= src_addr;
            end
        end
    end

    assign out_vld  = vld_q[STAGES-1];
    assign out_hit  = hit_q[STAGES-1];
    assign out_addr = addr_q[STAGES-1];

endmodule

// File: rtl/ras_verify.sv
module ras_verify #(
    parameter int AW       = 32,
    parameter bit SLOW_CMP = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_vld,
    input  logic          slot_hit,
    input  logic [AW-1:0] slot_addr,
    input  logic [AW-1:0] rf_link_val,
    input  logic          older_flush,
    output logic          fix_valid,
    output logic [AW-1:0] fix_pc,
    output logic          kill_f1,
    output logic          kill_f2,
    output logic          kill_d1
);

    logic miss;

    assign miss      = ~slot_hit | (slot_addr != rf_link_val);
    assign fix_valid = slot_vld & ~older_flush & miss;
    assign fix_pc    = fix_valid ? rf_link_val : '0;
    assign kill_f1   = fix_valid;
    assign kill_f2   = fix_valid;

    if (SLOW_CMP) begin : g_slow
        assign kill_d1 = fix_valid;
    end else begin : g_fast
        assign kill_d1 = 1'b0;
    end

    AST_KILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        kill_d1 |-> (kill_f1 && kill_f2)); // R5

    AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld && slot_hit && slot_addr == rf_link_val) |-> !(kill_f1 || kill_d1)); // R4

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor #(
    parameter int AW        = 32,
    parameter int DEPTH     = 8,
    parameter bit USE_STACK = 1'b1,
    parameter bit SLOW_CMP  = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d2_valid,
    input  logic          d2_is_call,
    input  logic          d2_is_ret,
    input  logic [AW-1:0] d2_link_addr,
    input  logic [AW-1:0] rf_link_val,
    input  logic          older_flush,
    output logic          redir_valid,
    output logic [AW-1:0] redir_pc,
    output logic          redir_hit,
    output logic          fix_valid,
    output logic [AW-1:0] fix_pc,
    output logic          kill_f1,
    output logic          kill_f2,
    output logic          kill_d1
);

    localparam int CARRY = 2; // D2 -> RN -> RF

    logic          dec_call, dec_ret;
    logic          p_hit;
    logic [AW-1:0] p_addr;
    logic          chk_vld, chk_hit;
    logic [AW-1:0] chk_addr;

    assign dec_call = d2_valid & d2_is_call & ~older_flush;
    assign dec_ret  = d2_valid & d2_is_ret & ~older_flush;

    if (USE_STACK) begin : g_stack
        logic [AW-1:0] top_addr;
        logic          top_hit;
        ras_stack #(.DEPTH(DEPTH), .AW(AW)) stack_i (
            .clk(clk), .rst_n(rst_n), .push(dec_call), .pop(dec_ret),
            .link_in(d2_link_addr), .top_addr(top_addr), .top_hit(top_hit)
        );
        assign redir_valid = dec_ret;
        assign redir_pc    = dec_ret ? top_addr : '0;
        assign redir_hit   = dec_ret & top_hit;
        assign p_hit       = top_hit;
        assign p_addr      = top_addr;
    end else begin : g_nostack
        logic unused_call;
        assign unused_call = dec_call ^ (^d2_link_addr);
        assign redir_valid = 1'b0;
        assign redir_pc    = '0;
        assign redir_hit   = 1'b0;
        assign p_hit       = 1'b0;
        assign p_addr      = '0;
    end

    ras_pipe #(.STAGES(CARRY), .AW(AW)) pipe_i (
        .clk(clk), .rst_n(rst_n), .flush(older_flush),
        .in_vld(dec_ret), .in_hit(p_hit), .in_addr(p_addr),
        .out_vld(chk_vld), .out_hit(chk_hit), .out_addr(chk_addr)
    );

    ras_verify #(.AW(AW), .SLOW_CMP(SLOW_CMP)) verify_i (
        .clk(clk), .rst_n(rst_n),
        .slot_vld(chk_vld), .slot_hit(chk_hit), .slot_addr(chk_addr),
        .rf_link_val(rf_link_val), .older_flush(older_flush),
        .fix_valid(fix_valid), .fix_pc(fix_pc),
        .kill_f1(kill_f1), .kill_f2(kill_f2), .kill_d1(kill_d1)
    );

    // cycles since reset, saturating, for history-based checks
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 1'b1;
    end

    AST_REDIR_NEEDS_RET: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (d2_valid && d2_is_ret && !older_flush)); // R2

    AST_FIX_AFTER_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_valid && age_q >= 2'd2) |-> $past(d2_valid && d2_is_ret, 2)); // R3

    AST_FLUSH_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        older_flush |=> !fix_valid); // R8

endmodule

// File: tb/ras_predictor_tb_top.sv
module ras_predictor_tb_top;

    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic d2_valid, d2_is_call, d2_is_ret, older_flush;
    logic [AW-1:0] d2_link_addr, rf_link_val;

    logic redir_valid, redir_hit, fix_valid, kill_f1, kill_f2, kill_d1;
    logic [AW-1:0] redir_pc, fix_pc;
    logic s_redir_valid, s_fix_valid, s_kill_d1, s_kill_f1, s_kill_f2, s_redir_hit;
    logic [AW-1:0] redir_pc_s, fix_pc_s;
    logic sl_fix_valid, sl_kill_d1, sl_redir_valid, sl_redir_hit, sl_kill_f1, sl_kill_f2;
    logic [AW-1:0] sl_redir_pc, sl_fix_pc;
    logic np_redir_valid, np_redir_hit, np_fix_valid, np_kill_f1, np_kill_f2, np_kill_d1;
    logic [AW-1:0] np_redir_pc, np_fix_pc;
    logic c_np_redir, c_np_fix, c_sl_fix, c_sl_kd1;
    logic [AW-1:0] c_np_fix_pc;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5ns clk = ~clk;

    ras_predictor #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .d2_valid(d2_valid), .d2_is_call(d2_is_call),
        .d2_is_ret(d2_is_ret), .d2_link_addr(d2_link_addr), .rf_link_val(rf_link_val),
        .older_flush(older_flush), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .redir_hit(redir_hit), .fix_valid(fix_valid), .fix_pc(fix_pc),
        .kill_f1(kill_f1), .kill_f2(kill_f2), .kill_d1(kill_d1)
    );

    ras_predictor #(.AW(AW), .SLOW_CMP(1'b1)) dut_slow_i (
        .clk(clk), .rst_n(rst_n), .d2_valid(d2_valid), .d2_is_call(d2_is_call),
        .d2_is_ret(d2_is_ret), .d2_link_addr(d2_link_addr), .rf_link_val(rf_link_val),
        .older_flush(older_flush), .redir_valid(sl_redir_valid), .redir_pc(sl_redir_pc),
        .redir_hit(sl_redir_hit), .fix_valid(sl_fix_valid), .fix_pc(sl_fix_pc),
        .kill_f1(sl_kill_f1), .kill_f2(sl_kill_f2), .kill_d1(sl_kill_d1)
    );

    ras_predictor #(.AW(AW), .USE_STACK(1'b0)) dut_np_i (
        .clk(clk), .rst_n(rst_n), .d2_valid(d2_valid), .d2_is_call(d2_is_call),
        .d2_is_ret(d2_is_ret), .d2_link_addr(d2_link_addr), .rf_link_val(rf_link_val),
        .older_flush(older_flush), .redir_valid(np_redir_valid), .redir_pc(np_redir_pc),
        .redir_hit(np_redir_hit), .fix_valid(np_fix_valid), .fix_pc(np_fix_pc),
        .kill_f1(np_kill_f1), .kill_f2(np_kill_f2), .kill_d1(np_kill_d1)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one cycle: drive after negedge, sample 1ns later, move to next negedge
    task automatic tick(input logic call, input logic ret, input logic [AW-1:0] link,
                        input logic [AW-1:0] rfv, input logic fl);
        d2_valid     = call | ret;
        d2_is_call   = call;
        d2_is_ret    = ret;
        d2_link_addr = link;
        rf_link_val  = rfv;
        older_flush  = fl;
        #1ns;
        s_redir_valid = redir_valid; s_redir_hit = redir_hit; redir_pc_s = redir_pc;
        s_fix_valid = fix_valid; fix_pc_s = fix_pc;
        s_kill_f1 = kill_f1; s_kill_f2 = kill_f2; s_kill_d1 = kill_d1;
        c_np_redir = np_redir_valid; c_np_fix = np_fix_valid; c_np_fix_pc = np_fix_pc;
        c_sl_fix = sl_fix_valid; c_sl_kd1 = sl_kill_d1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        d2_valid = 0; d2_is_call = 0; d2_is_ret = 0; older_flush = 0;
        d2_link_addr = '0; rf_link_val = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        #1ns;
        check(!redir_valid && !fix_valid && !kill_f1 && !kill_f2 && !kill_d1,
              "R11", "outputs after reset", {redir_valid, fix_valid, kill_f1, kill_f2, kill_d1}, 0);
        @(negedge clk);
    endtask

    task automatic t_empty_pop();
        do_reset();
        tick(0, 1, '0, '0, 0);
        check(s_redir_valid && !s_redir_hit && redir_pc_s == 0, "R7", "empty pop redirect",
              {s_redir_valid, s_redir_hit}, 2'b10);
        tick(0, 0, '0, '0, 0);
        tick(0, 0, '0, 32'h0, 0);
        check(s_fix_valid && fix_pc_s == 0, "R7", "empty pop counted as mismatch", s_fix_valid, 1);
    endtask

    task automatic t_call_ret();
        do_reset();
        tick(1, 0, 32'h1000, '0, 0);
        tick(1, 0, 32'h2000, '0, 0);
        tick(0, 1, '0, '0, 0);
        check(s_redir_valid && s_redir_hit && redir_pc_s == 32'h2000, "R1", "lifo first pop",
              redir_pc_s, 32'h2000);
        tick(0, 1, '0, '0, 0);
        check(s_redir_valid && redir_pc_s == 32'h1000, "R2", "second pop redirect", redir_pc_s, 32'h1000);
        tick(0, 0, '0, 32'h2000, 0);
        check(!s_fix_valid && !s_kill_f1 && !s_kill_f2 && !s_kill_d1, "R4", "match quiet",
              {s_fix_valid, s_kill_f1, s_kill_f2, s_kill_d1}, 0);
        tick(0, 0, '0, 32'h1234, 0);
        check(s_fix_valid && fix_pc_s == 32'h1234, "R3", "mismatch fix pc", fix_pc_s, 32'h1234);
        check(s_kill_f1 && s_kill_f2 && !s_kill_d1, "R5", "fast kills",
              {s_kill_f1, s_kill_f2, s_kill_d1}, 3'b110);
        check(c_sl_fix && c_sl_kd1, "R5", "slow compare kills D1", c_sl_kd1, 1);
        check(!s_redir_valid, "R2", "no redirect without return", s_redir_valid, 0);
    endtask

    task automatic t_overwrite();
        do_reset();
        for (int i = 1; i <= 9; i++) tick(1, 0, 32'(i * 16), '0, 0);
        for (int i = 9; i >= 2; i--) begin
            tick(0, 1, '0, '0, 0);
            check(s_redir_hit && redir_pc_s == 32'(i * 16), "R6", "pop after wrap",
                  redir_pc_s, 32'(i * 16));
        end
        tick(0, 1, '0, '0, 0);
        check(s_redir_valid && !s_redir_hit, "R6", "ninth pop empty", s_redir_hit, 0);
    endtask

    task automatic t_flush();
        do_reset();
        tick(1, 0, 32'hA0, '0, 0);
        tick(1, 0, 32'hC0, '0, 1);
        tick(0, 1, '0, '0, 1);
        check(!s_redir_valid, "R8", "return ignored under flush", s_redir_valid, 0);
        tick(0, 1, '0, '0, 0);
        check(s_redir_hit && redir_pc_s == 32'hA0, "R8", "flushed call not pushed", redir_pc_s, 32'hA0);
        tick(0, 0, '0, 32'h55, 1);
        check(!s_fix_valid, "R8", "no fix in flush cycle", s_fix_valid, 0);
        tick(0, 0, '0, 32'h55, 0);
        check(!s_fix_valid, "R8", "in-flight return cancelled", s_fix_valid, 0);
    endtask

    task automatic t_swap();
        do_reset();
        tick(1, 0, 32'h11, '0, 0);
        tick(1, 0, 32'h22, '0, 0);
        tick(1, 1, 32'h33, '0, 0);
        check(s_redir_valid && redir_pc_s == 32'h22, "R9", "swap predicts top", redir_pc_s, 32'h22);
        tick(0, 1, '0, '0, 0);
        check(redir_pc_s == 32'h33, "R9", "top replaced", redir_pc_s, 32'h33);
        tick(0, 1, '0, '0, 0);
        check(s_redir_hit && redir_pc_s == 32'h11, "R9", "depth unchanged", redir_pc_s, 32'h11);
    endtask

    task automatic t_bubbles();
        int off_s, off_n;
        bit np_redir_seen;
        do_reset();
        off_s = -1; off_n = -1; np_redir_seen = 0;
        tick(1, 0, 32'h700, '0, 0);
        for (int k = 0; k < 4; k++) begin
            tick(0, (k == 0), '0, 32'h700, 0);
            if (s_redir_valid && off_s < 0) off_s = k;
            if (c_np_fix && off_n < 0) begin
                off_n = k;
                check(c_np_fix_pc == 32'h700, "R10", "no-stack fix pc", c_np_fix_pc, 32'h700);
            end
            if (c_np_redir) np_redir_seen = 1;
        end
        // return reaches D2 four cycles after its PC cycle
        check(off_s >= 0 && off_s + 4 == 4, "R10", "bubbles with stack", off_s + 4, 4);
        check(off_n >= 0 && off_n + 4 == 6, "R10", "bubbles without stack", off_n + 4, 6);
        check(!np_redir_seen, "R10", "no early redirect without stack", np_redir_seen, 0);
    endtask

    initial begin
        #(5ns * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_empty_pop();
        t_call_ret();
        t_overwrite();
        t_flush();
        t_swap();
        t_bubbles();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule